// File: doc/BRIEF.md
# USB Low-Speed Packet Receiver

This block recovers the bytes of a low-speed USB packet from the two data lines. The lines are sampled by a 16 MHz system clock, and both are assumed to be synchronised to that clock already. The receiver first waits for the line to move from idle into the sync field. It then finds the exact clock on which the line falls from J to K, and checks that a second K follows about one and a half bit times later. After that it samples each following bit near its centre. At 16 MHz one bit lasts 10⅔ clocks, so the receiver uses a repeating pattern of 10- and 11-clock intervals plus an occasional leap clock.

Each sampled bit is decoded from NRZI, and bits inserted by stuffing are dropped. Data bits are packed into bytes least significant bit first. Each finished byte is presented with a one-clock strobe. An SE0 on the line ends the packet and reports how many whole bytes arrived. Three events abort a packet:

- more bytes arrive than the configured limit;
- a stuffing rule is broken;
- no J-to-K edge appears in time during the sync hunt.

After an abort the receiver waits for the packet to end. PID, CRC and address checks are left to the logic downstream.

Top module: `usb_ls_rx`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, every output is 0.
- R2: Line states are J = (`dp`=0, `dm`=1), K = (`dp`=1, `dm`=0) and SE0 = (both 0). In the idle state, a clock whose sample is K after a clock whose sample was J arms a confirmation. Sixteen clocks later the line is sampled again. If that sample is K, data reception starts. Otherwise the receiver goes into a hunt for the next J-to-K edge.
- R3: The first data bit is sampled 11 clocks after the confirming sample. Later data bits follow at 11, 11, 10, 11, 11, 10, 11, 10 clocks, indexed by the bit's position within its byte. One extra clock is added to the first interval of every third byte, starting after the third byte. A stuffed bit takes 11 clocks and delays the next leap clock by one byte. Across a packet of 8 bytes, the bit timing stays within the bit period of a sender running at exactly 10⅔ clocks per bit.
- R4: NRZI decoding gives 1 when the `dm` level equals the level at the previous sample, and 0 when it differs. The reference level at the start of data is that of the final K of the sync field.
- R5: Data bits fill each byte from bit 0 up to bit 7. When a byte is complete, `byte_valid` is high for exactly one clock and `byte_data` holds the byte during that clock.
- R6: Runs of 1s are counted from the final 1 of the sync field onward. After six consecutive 1s, the next bit is removed if it is a 0, and it does not count as data.
- R7: A 1 in the position of a stuffed bit raises `stuff_err` for one clock and abandons the packet. For that packet, no further `byte_valid` and no `pkt_done` follow.
- R8: An SE0 seen at a sample point raises `pkt_done` for one clock. `pkt_len` then equals the number of whole bytes delivered in that packet. Bits of an unfinished byte are discarded.
- R9: If a byte completes when `MAX_BYTES` bytes have already been delivered, `overflow` is raised for one clock in place of `byte_valid`. The packet is then abandoned and gives no `pkt_done`. A later packet is received normally.
- R10: In the hunt state, if `HUNT_LIMIT` (64) clocks pass with no J-to-K edge, `sync_timeout` is raised for one clock and the receiver returns to idle. A later packet is received normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 16 MHz system clock |
| rst | input | 1 | Synchronous active-high reset |
| dp | input | 1 | Synchronised D+ sample |
| dm | input | 1 | Synchronised D- sample |
| byte_data | output | 8 | Received byte, valid with `byte_valid` |
| byte_valid | output | 1 | One-clock strobe per received byte |
| pkt_done | output | 1 | One-clock strobe at end of packet |
| pkt_len | output | LEN_W (4) | Whole bytes in the packet, valid with `pkt_done` |
| overflow | output | 1 | One-clock strobe: byte limit exceeded, packet abandoned |
| stuff_err | output | 1 | One-clock strobe: bit-stuff rule violated, packet abandoned |
| sync_timeout | output | 1 | One-clock strobe: sync hunt expired |

## Verification
A fault in the sample-interval or leap logic makes the sample point drift a little on every byte. That drift shows at the ports as corrupted bytes within a few bytes, so long packets are needed to expose it. A wrong run-of-ones count or NRZI reference shows within the first data byte:

- the bytes are shifted;
- or a stuff error appears where none belongs.

A fault in the byte or hunt counters shows up at the packet boundary only: a wrong `pkt_len`, an overflow that is missing or comes too early, or a timeout that never fires. Every strobe is therefore compared in order against the expected events derived from the bit stream that the bench sends.

// File: rtl/usb_ls_rx_pkg.sv
package usb_ls_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CONF,
    ST_HUNT,
    ST_RECV,
    ST_DRAIN,
    ST_WAITJ
  } rx_state_t;

  // consecutive ones after which a stuffed zero is expected
  localparam int STUFF_RUN   = 6;
  // one leap clock per this many bytes
  localparam int LEAP_PERIOD = 3;

  // within-byte slot lengths: 11 clocks except at positions 2, 5 and 7
  function automatic logic long_slot(input logic [2:0] pos);
    return !((pos == 3'd2) || (pos == 3'd5) || (pos == 3'd7));
  endfunction

endpackage

// File: rtl/usb_ls_line_dec.sv
module usb_ls_line_dec (
  input  logic clk,
  input  logic rst,
  input  logic dp,
  input  logic dm,
  output logic is_j,
  output logic is_k,
  output logic is_se0,
  output logic jk_edge
);
  logic prev_j;

  assign is_j   = !dp &&  dm;
  assign is_k   =  dp && !dm;
  assign is_se0 = !dp && !dm;
  assign jk_edge = prev_j && is_k;

  always_ff @(posedge clk) begin
    if (rst) prev_j <= 1'b0;
    else     prev_j <= is_j;
  end

  // an edge is only reported on the first K after a J (R2)
  p_edge_first_k_r2: assert property (@(posedge clk) disable iff (rst)
    jk_edge |=> !jk_edge);

endmodule

// File: rtl/usb_ls_bit_timer.sv
module usb_ls_bit_timer #(
  parameter int TMR_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             load,
  input  logic [TMR_W-1:0] load_val,
  output logic             tick
);
  logic [TMR_W-1:0] cnt;

  assign tick = run && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst)                     cnt <= '0;
    else if (load)               cnt <= load_val - TMR_W'(1);
    else if (run && cnt != '0)   cnt <= cnt - TMR_W'(1);
  end

  // a reload always asks for at least one clock of delay (R3)
  p_load_nonzero_r3: assert property (@(posedge clk) disable iff (rst)
    load |-> (load_val != '0));

endmodule

// File: rtl/usb_ls_deser.sv
module usb_ls_deser
  import usb_ls_rx_pkg::*;
#(
  parameter int ONES_W = $clog2(STUFF_RUN + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              sample,
  input  logic              lvl,
  output logic              stuffed,
  output logic              stuff_fail,
  output logic              byte_done,
  output logic [7:0]        byte_out,
  output logic [2:0]        next_pos,
  output logic [ONES_W-1:0] next_ones
);
  logic              prev_lvl;
  logic [ONES_W-1:0] ones;
  logic [2:0]        pos;
  logic [6:0]        sr;
  logic              bit_now;
  logic              at_stuff;

  assign bit_now    = (lvl == prev_lvl);
  assign at_stuff   = (ones == ONES_W'(STUFF_RUN));
  assign stuffed    = sample && at_stuff && !bit_now;
  assign stuff_fail = sample && at_stuff &&  bit_now;
  assign byte_done  = sample && !at_stuff && (pos == 3'd7);
  assign byte_out   = {bit_now, sr};

  always_comb begin
    next_ones = ones;
    next_pos  = pos;
    if (sample) begin
      if (at_stuff) begin
        next_ones = '0;
      end else begin
        next_ones = bit_now ? ones + ONES_W'(1) : '0;
        next_pos  = pos + 3'd1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_lvl <= 1'b0;
      ones     <= '0;
      pos      <= '0;
      sr       <= '0;
    end else if (start) begin
      prev_lvl <= 1'b0;          // dm level of the final sync K
      ones     <= ONES_W'(1);    // sync field ends in one decoded 1
      pos      <= '0;
      sr       <= '0;
    end else if (sample) begin
      prev_lvl <= lvl;
      ones     <= next_ones;
      pos      <= next_pos;
      if (!at_stuff) sr <= {bit_now, sr[6:1]};
    end
  end

  p_ones_bound_r6: assert property (@(posedge clk) disable iff (rst)
    ones <= ONES_W'(STUFF_RUN));

  p_stuff_no_data_r6: assert property (@(posedge clk) disable iff (rst)
    (sample && at_stuff && !start) |=> $stable(pos));

endmodule

// File: rtl/usb_ls_rx.sv
module usb_ls_rx
  import usb_ls_rx_pkg::*;
#(
  parameter int MAX_BYTES  = 8,
  parameter int BIT_BASE   = 10,
  parameter int HUNT_LIMIT = 64,
  parameter int LEAP_W     = 8,
  localparam int LEN_W     = $clog2(MAX_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dp,
  input  logic             dm,
  output logic [7:0]       byte_data,
  output logic             byte_valid,
  output logic             pkt_done,
  output logic [LEN_W-1:0] pkt_len,
  output logic             overflow,
  output logic             stuff_err,
  output logic             sync_timeout
);
  localparam int CONF_CLKS = BIT_BASE + BIT_BASE / 2 + 1;
  localparam int TMR_W     = $clog2(CONF_CLKS + 1);
  localparam int HUNT_W    = $clog2(HUNT_LIMIT + 1);
  localparam int ONES_W    = $clog2(STUFF_RUN + 1);

  rx_state_t state;

  logic is_j, is_k, is_se0, jk_edge;
  logic tick, tmr_run, tmr_load;
  logic [TMR_W-1:0] tmr_val;

  logic d_start, d_sample;
  logic stuffed, stuff_fail, byte_done;
  logic [7:0] byte_next;
  logic [2:0] next_pos;
  logic [ONES_W-1:0] next_ones;

  logic [LEN_W-1:0]         byte_cnt;
  logic [HUNT_W-1:0]        hunt_cnt;
  logic signed [LEAP_W-1:0] leap_cnt;
  logic signed [LEAP_W-1:0] leap_dec;
  logic                     leap_hit;
  logic                     recv_go;
  logic                     at_limit;
  logic [TMR_W-1:0]         slot_len;

  usb_ls_line_dec u_line (
    .clk    (clk),
    .rst    (rst),
    .dp     (dp),
    .dm     (dm),
    .is_j   (is_j),
    .is_k   (is_k),
    .is_se0 (is_se0),
    .jk_edge(jk_edge)
  );

  usb_ls_bit_timer #(.TMR_W(TMR_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .run     (tmr_run),
    .load    (tmr_load),
    .load_val(tmr_val),
    .tick    (tick)
  );

  usb_ls_deser #(.ONES_W(ONES_W)) u_deser (
    .clk       (clk),
    .rst       (rst),
    .start     (d_start),
    .sample    (d_sample),
    .lvl       (dm),
    .stuffed   (stuffed),
    .stuff_fail(stuff_fail),
    .byte_done (byte_done),
    .byte_out  (byte_next),
    .next_pos  (next_pos),
    .next_ones (next_ones)
  );

  assign tmr_run  = (state == ST_CONF) || (state == ST_RECV);
  assign d_sample = tick && (state == ST_RECV) && !is_se0;
  assign d_start  = tick && (state == ST_CONF) && is_k;
  assign at_limit = (byte_cnt == LEN_W'(MAX_BYTES));
  assign leap_dec = leap_cnt - LEAP_W'(1);
  assign leap_hit = byte_done && leap_dec[LEAP_W-1];
  assign recv_go  = d_sample && !stuff_fail && !(byte_done && at_limit);

  // length of the interval up to the next sample point
  always_comb begin
    if (next_ones == ONES_W'(STUFF_RUN))
      slot_len = TMR_W'(BIT_BASE + 1);
    else
      slot_len = TMR_W'(BIT_BASE) + TMR_W'(long_slot(next_pos));
  end

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = TMR_W'(CONF_CLKS);
    if (((state == ST_IDLE) || (state == ST_HUNT)) && jk_edge) begin
      tmr_load = 1'b1;
    end else if (d_start) begin
      tmr_load = 1'b1;
      tmr_val  = TMR_W'(BIT_BASE) + TMR_W'(long_slot(3'd0));
    end else if (recv_go) begin
      tmr_load = 1'b1;
      tmr_val  = slot_len + TMR_W'(leap_hit);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      byte_data    <= '0;
      byte_valid   <= 1'b0;
      pkt_done     <= 1'b0;
      pkt_len      <= '0;
      overflow     <= 1'b0;
      stuff_err    <= 1'b0;
      sync_timeout <= 1'b0;
      byte_cnt     <= '0;
      hunt_cnt     <= '0;
      leap_cnt     <= '0;
    end else begin
      byte_valid   <= 1'b0;
      pkt_done     <= 1'b0;
      overflow     <= 1'b0;
      stuff_err    <= 1'b0;
      sync_timeout <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (jk_edge) state <= ST_CONF;
        end
        ST_CONF: begin
          if (tick) begin
            if (is_k) begin
              state    <= ST_RECV;
              byte_cnt <= '0;
              leap_cnt <= LEAP_W'(LEAP_PERIOD - 1);
            end else begin
              state    <= ST_HUNT;
              hunt_cnt <= '0;
            end
          end
        end
        ST_HUNT: begin
          if (jk_edge) begin
            state <= ST_CONF;
          end else if (hunt_cnt == HUNT_W'(HUNT_LIMIT - 1)) begin
            state        <= ST_IDLE;
            sync_timeout <= 1'b1;
          end else begin
            hunt_cnt <= hunt_cnt + HUNT_W'(1);
          end
        end
        ST_RECV: begin
          if (tick) begin
            if (is_se0) begin
              pkt_done <= 1'b1;
              pkt_len  <= byte_cnt;
              state    <= ST_WAITJ;
            end else if (stuff_fail) begin
              stuff_err <= 1'b1;
              state     <= ST_DRAIN;
            end else if (byte_done && at_limit) begin
              overflow <= 1'b1;
              state    <= ST_DRAIN;
            end else begin
              if (byte_done) begin
                byte_valid <= 1'b1;
                byte_data  <= byte_next;
                byte_cnt   <= byte_cnt + LEN_W'(1);
                leap_cnt   <= leap_hit ? leap_dec + LEAP_W'(LEAP_PERIOD) : leap_dec;
              end else if (stuffed) begin
                leap_cnt <= leap_cnt + LEAP_W'(1);
              end
            end
          end
        end
        ST_DRAIN: begin
          if (is_se0) state <= ST_WAITJ;
        end
        ST_WAITJ: begin
          if (is_j) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // ---------------- assertions ----------------
  p_interval_range_r3: assert property (@(posedge clk) disable iff (rst)
    recv_go |-> (tmr_val >= TMR_W'(BIT_BASE) && tmr_val <= TMR_W'(BIT_BASE + 2)));

  p_leap_nonneg_r3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RECV) |-> (leap_cnt >= 0));

  p_valid_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    byte_valid |=> !byte_valid);

  p_events_onehot_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({byte_valid, pkt_done, overflow, stuff_err, sync_timeout}));

  p_abort_drains_r7: assert property (@(posedge clk) disable iff (rst)
    stuff_err |-> (state == ST_DRAIN));

  p_done_len_r8: assert property (@(posedge clk) disable iff (rst)
    pkt_done |-> (pkt_len <= LEN_W'(MAX_BYTES) && state == ST_WAITJ));

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
    byte_cnt <= LEN_W'(MAX_BYTES));

  p_timeout_idle_r10: assert property (@(posedge clk) disable iff (rst)
    sync_timeout |-> (state == ST_IDLE));

  p_conf_entry_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(state == ST_CONF) |-> ($past(state) == ST_IDLE || $past(state) == ST_HUNT));

endmodule

// File: tb/usb_ls_rx_tb.sv
`timescale 1ns/1ps
module usb_ls_rx_tb;
  localparam int CLK_PERIOD = 62;
  localparam int MAXB = 8;
  localparam int LW = $clog2(MAXB + 1);
  localparam int K_BYTE = 0, K_DONE = 1, K_OVF = 2, K_SERR = 3, K_TOUT = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dp = 1'b0, dm = 1'b1;
  logic [7:0] byte_data;
  logic byte_valid, pkt_done, overflow, stuff_err, sync_timeout;
  logic [LW-1:0] pkt_len;

  usb_ls_rx #(.MAX_BYTES(MAXB)) u_dut (
    .clk(clk), .rst(rst), .dp(dp), .dm(dm),
    .byte_data(byte_data), .byte_valid(byte_valid), .pkt_done(pkt_done),
    .pkt_len(pkt_len), .overflow(overflow), .stuff_err(stuff_err),
    .sync_timeout(sync_timeout)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  typedef struct { int kind; int val; string tag; } exp_t;
  exp_t q[$];
  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  logic [1:0] sym[$];
  bit lvl_k;
  int ones;

  function automatic void check(bit ok, string tag, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endfunction

  function automatic void expect_ev(int k, int v, string t);
    exp_t e;
    e.kind = k; e.val = v; e.tag = t;
    q.push_back(e);
  endfunction

  function automatic void got(int k, int v);
    exp_t e;
    n_tests++;
    if (q.size() == 0) begin
      n_fail++;
      $display("FAIL unexpected event: actual kind %0d val %0h expected none", k, v);
    end else begin
      e = q.pop_front();
      if (e.kind != k || e.val != v) begin
        n_fail++;
        $display("FAIL %s: actual kind %0d val %0h expected kind %0d val %0h",
                 e.tag, k, v, e.kind, e.val);
      end
    end
  endfunction

  // monitor: compare every strobe against the scoreboard
  always @(negedge clk) begin
    if (!rst && !finished) begin
      if (byte_valid)   got(K_BYTE, int'(byte_data));
      if (pkt_done)     got(K_DONE, int'(pkt_len));
      if (overflow)     got(K_OVF, 0);
      if (stuff_err)    got(K_SERR, 0);
      if (sync_timeout) got(K_TOUT, 0);
    end
  end

  // NRZI line symbol builder: 0 toggles, 1 keeps; symbol is {dp,dm}
  function automatic void enc(bit b);
    if (!b) lvl_k = !lvl_k;
    sym.push_back(lvl_k ? 2'b10 : 2'b01);
  endfunction

  function automatic void put_bit(bit b, bit stuff_en);
    enc(b);
    if (b) ones++; else ones = 0;
    if (stuff_en && ones == 6) begin
      enc(1'b0);
      ones = 0;
    end
  endfunction

  function automatic void begin_pkt();
    sym.delete();
    lvl_k = 1'b0;
    ones = 0;
    for (int i = 0; i < 7; i++) put_bit(1'b0, 1'b1);
    put_bit(1'b1, 1'b1);
  endfunction

  function automatic void put_byte(logic [7:0] b, bit stuff_en);
    for (int i = 0; i < 8; i++) put_bit(b[i], stuff_en);
  endfunction

  function automatic void end_pkt();
    sym.push_back(2'b00);
    sym.push_back(2'b00);
    sym.push_back(2'b01);
  endfunction

  // bit k starts at clock ceil(32k/3): exactly 10 2/3 clocks per bit
  task automatic play();
    for (int c = 0; (3 * c) / 32 < sym.size(); c++) begin
      @(negedge clk);
      {dp, dm} = sym[(3 * c) / 32];
    end
    @(negedge clk);
    {dp, dm} = 2'b01;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bytes(logic [7:0] data[$], string tag);
    begin_pkt();
    foreach (data[i]) begin
      put_byte(data[i], 1'b1);
      if (i < MAXB) expect_ev(K_BYTE, int'(data[i]), tag);
    end
    end_pkt();
    if (data.size() > MAXB) expect_ev(K_OVF, 0, "R9 overflow");
    else expect_ev(K_DONE, data.size(), tag);
    play();
    idle(30);
  endtask

  task automatic drain(string tag);
    int w;
    w = 0;
    while (q.size() != 0 && w < 2000) begin
      @(negedge clk);
      w++;
    end
    check(q.size() == 0, tag, q.size(), 0);
  endtask

  initial begin
    logic [7:0] d[$];
    {dp, dm} = 2'b01;
    // R1: reset state
    repeat (4) @(negedge clk);
    check({byte_valid, pkt_done, overflow, stuff_err, sync_timeout} == 5'b0, "R1 strobes in reset",
          int'({byte_valid, pkt_done, overflow, stuff_err, sync_timeout}), 0);
    check(pkt_len == '0 && byte_data == '0, "R1 data in reset", int'({pkt_len, byte_data}), 0);
    rst = 1'b0;
    @(negedge clk);
    check({byte_valid, pkt_done, overflow, stuff_err, sync_timeout} == 5'b0, "R1 after reset",
          int'({byte_valid, pkt_done, overflow, stuff_err, sync_timeout}), 0);
    idle(10);

    // R2 R4 R5: basic packet
    d = '{8'hC3, 8'h5A, 8'h01};
    send_bytes(d, "R4 R5 basic packet");
    drain("R2 basic packet delivered");

    // R6: stuffing inside and across bytes, incl. run continuing from sync
    d = '{8'h3F, 8'hFF, 8'hFF, 8'h80};
    send_bytes(d, "R6 destuff");
    drain("R6 destuff delivered");

    // R3: full-size packet exercising leap clocks
    d = '{8'h00, 8'hAA, 8'h55, 8'hFF, 8'h0F, 8'hF0, 8'h00, 8'h7E};
    send_bytes(d, "R3 long packet");
    drain("R3 long packet delivered");

    // R9: one byte beyond the limit
    d = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 8'h77, 8'h88, 8'h99};
    send_bytes(d, "R9 bytes before overflow");
    drain("R9 overflow reported");
    d = '{8'hA5};
    send_bytes(d, "R9 recovery packet");
    drain("R9 recovery delivered");

    // R7: unstuffed run of ones
    begin_pkt();
    put_byte(8'hFF, 1'b0);
    put_byte(8'hFF, 1'b0);
    end_pkt();
    expect_ev(K_SERR, 0, "R7 stuff error");
    play();
    idle(30);
    drain("R7 stuff error reported");

    // R8: zero-length packet
    begin_pkt();
    end_pkt();
    expect_ev(K_DONE, 0, "R8 zero length");
    play();
    idle(30);
    drain("R8 zero length delivered");

    // R8: SE0 in the middle of a byte
    begin_pkt();
    put_byte(8'h12, 1'b1);
    put_bit(1'b0, 1'b1); put_bit(1'b1, 1'b1); put_bit(1'b0, 1'b1); put_bit(1'b1, 1'b1);
    end_pkt();
    expect_ev(K_BYTE, 8'h12, "R8 partial byte packet");
    expect_ev(K_DONE, 1, "R8 partial byte dropped");
    play();
    idle(30);
    drain("R8 partial delivered");

    // R10: lone K, confirm fails, hunt expires
    sym.delete();
    sym.push_back(2'b10);
    expect_ev(K_TOUT, 0, "R10 hunt timeout");
    play();
    idle(150);
    drain("R10 timeout reported");
    d = '{8'h7E, 8'h3C};
    send_bytes(d, "R10 packet after timeout");
    drain("R10 recovery delivered");

    idle(20);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      finished = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule